// File: doc/BRIEF.md
# Delayed-Access Prefetch Engine

This block sits beside a processor's load and store buffers. When the memory-ordering logic keeps a load, store or atomic read-modify-write waiting, that logic hands the line address to this engine. The engine then fetches the line early, without binding any value. A load asks for a shared copy. A store or atomic asks for an owned, exclusive copy, so the real write can complete quickly once ordering allows it.

Hints wait in a small slot table and are checked against the cache tags in arrival order. A line that is already cached, or whose lookup reports a fault, is dropped without any signal to the processor. Any other line becomes a memory request, and the returned line is written into the cache with the state it ended up in.

While a request is outstanding, the engine watches three kinds of traffic on that line. A demand access from the processor joins the request instead of sending a second one. A remote write poisons the line, so it is not filled and the joined access is told to refetch. A remote read downgrades an exclusive request to shared.

Top module: `pf_delayed_access`

## Requirements
- R1: A hint with `pf_store`=0 (delayed load) produces a memory request with `mem_req_excl`=0. A hint with `pf_store`=1 (delayed store or atomic) produces one with `mem_req_excl`=1.
- R2: A hint whose tag lookup reports `lk_hit`=1 is discarded and never reaches the memory port.
- R3: A hint whose lookup reports `lk_fault`=1 is discarded silently: no memory request and no other output.
- R4: A matching memory response makes `fill_valid` high for one cycle, in the cycle after the response. `fill_line` equals the response line, and `fill_excl` follows the request type. An issued request stays stable until `mem_req_ready` is high.
- R5: A hint whose line matches a line already held in the table (queued or outstanding) is ignored.
- R6: When all DEPTH slots are occupied, a new hint is dropped without stalling. Once a slot frees, hints are accepted again.
- R7: Accepted hints reach the lookup and memory ports in the order they arrived.
- R8: A demand access (`dem_valid`) to an outstanding line raises `dem_join` in the next cycle and issues no new request. When the response arrives, `dem_done` pulses in the same cycle as the fill. A demand to a line that is not outstanding gives `dem_join`=0.
- R9: A snooped remote write (`snp_write`=1) to an outstanding line suppresses its fill. If a demand had joined that line, `dem_retry` pulses instead of `dem_done`.
- R10: A snooped remote read (`snp_write`=0) to an outstanding exclusive line makes its fill arrive with `fill_excl`=0.
- R11: After reset, `lk_valid`, `mem_req_valid`, `fill_valid`, `dem_join`, `dem_done` and `dem_retry` are all low.
- R12: Responses are matched by line and may come back in any order. A response for a line that is not outstanding produces no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_valid | input | 1 | Prefetch hint for a delayed access |
| pf_store | input | 1 | 1 = store/atomic (exclusive), 0 = load (shared) |
| pf_line | input | LINE_W | Line address of the hint |
| lk_valid | output | 1 | Tag lookup request for the oldest queued hint |
| lk_line | output | LINE_W | Line being looked up |
| lk_hit | input | 1 | Line already present in the cache |
| lk_fault | input | 1 | Lookup reported a fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_excl | output | 1 | 1 = read-exclusive, 0 = read |
| mem_req_line | output | LINE_W | Requested line |
| mem_req_ready | input | 1 | Memory port accepts request |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_line | input | LINE_W | Line of the response |
| fill_valid | output | 1 | Write returned line into the cache |
| fill_line | output | LINE_W | Line to fill |
| fill_excl | output | 1 | Fill state: 1 exclusive, 0 shared |
| dem_valid | input | 1 | Processor demand access |
| dem_line | input | LINE_W | Line of the demand access |
| dem_join | output | 1 | Demand merged with an outstanding request |
| dem_done | output | 1 | Merged demand completes |
| dem_retry | output | 1 | Merged demand must refetch (line poisoned) |
| snp_valid | input | 1 | Snooped remote access |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_line | input | LINE_W | Snooped line |

## Verification
A stale slot state shows at the memory port. A slot left occupied makes a later duplicate or a full table drop hints that should go out. A slot freed too early lets a second request for the same line leave. Both show within a few cycles as an extra or missing request against the scoreboard.

Lost per-slot flags show in the single cycle after the response. A missing join, poison or downgrade flag appears as a wrong `fill_excl`, an unwanted fill, or `dem_done` where `dem_retry` was due. A broken issue order shows as soon as two queued hints are issued.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    SL_FREE   = 2'd0,
    SL_QUEUED = 2'd1,
    SL_SENT   = 2'd2
  } slot_st_e;
endpackage

// File: rtl/pf_order_fifo.sv
module pf_order_fifo #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [IDX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_idx = mem[rd_ptr];
  assign empty    = (cnt == '0);

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CNT_W'(DEPTH)) || pop); // R6
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0); // R7
endmodule

// File: rtl/pf_slots.sv
module pf_slots
  import pf_pkg::*;
#(
  parameter int N      = 4,
  parameter int LINE_W = 26,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic              alloc_excl,
  output logic              alloc_ok,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              iss_take,
  input  logic              iss_drop,
  input  logic [IDX_W-1:0]  iss_idx,
  output logic [LINE_W-1:0] iss_line,
  output logic              iss_excl,
  input  logic              rsp_valid,
  input  logic [LINE_W-1:0] rsp_line,
  output logic              rsp_hit,
  output logic              rsp_excl,
  output logic              rsp_merged,
  output logic              rsp_poison,
  input  logic              dem_valid,
  input  logic [LINE_W-1:0] dem_line,
  output logic              dem_hit,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [LINE_W-1:0] snp_line
);
  slot_st_e          st_q     [N];
  logic [LINE_W-1:0] line_q   [N];
  logic [N-1:0]      excl_q, merged_q, poison_q;

  logic [N-1:0]     dup_vec, rsp_vec, dem_vec, snp_vec;
  logic             any_free;
  logic [IDX_W-1:0] rsp_idx;

  always_comb begin
    any_free  = 1'b0;
    alloc_idx = '0;
    rsp_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      dup_vec[i] = (st_q[i] != SL_FREE) && (line_q[i] == alloc_line);
      rsp_vec[i] = rsp_valid && (st_q[i] == SL_SENT) && (line_q[i] == rsp_line);
      dem_vec[i] = dem_valid && (st_q[i] == SL_SENT) && (line_q[i] == dem_line) && !rsp_vec[i];
      snp_vec[i] = snp_valid && (st_q[i] == SL_SENT) && (line_q[i] == snp_line) && !rsp_vec[i];
      if (st_q[i] == SL_FREE) begin
        any_free  = 1'b1;
        alloc_idx = IDX_W'(i);
      end
      if (rsp_vec[i]) rsp_idx = IDX_W'(i);
    end
  end

  assign alloc_ok   = alloc && any_free && !(|dup_vec);
  assign rsp_hit    = |rsp_vec;
  assign dem_hit    = |dem_vec;
  assign rsp_excl   = excl_q[rsp_idx];
  assign rsp_merged = merged_q[rsp_idx];
  assign rsp_poison = poison_q[rsp_idx];
  assign iss_line   = line_q[iss_idx];
  assign iss_excl   = excl_q[iss_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        st_q[i]     <= SL_FREE;
        line_q[i]   <= '0;
        excl_q[i]   <= 1'b0;
        merged_q[i] <= 1'b0;
        poison_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_ok && alloc_idx == IDX_W'(i)) begin
          st_q[i]     <= SL_QUEUED;
          line_q[i]   <= alloc_line;
          excl_q[i]   <= alloc_excl;
          merged_q[i] <= 1'b0;
          poison_q[i] <= 1'b0;
        end
        if (iss_take && iss_idx == IDX_W'(i)) st_q[i] <= iss_drop ? SL_FREE : SL_SENT;
        if (rsp_vec[i]) st_q[i] <= SL_FREE;
        if (dem_vec[i]) merged_q[i] <= 1'b1;
        if (snp_vec[i] && snp_write)  poison_q[i] <= 1'b1;
        if (snp_vec[i] && !snp_write) excl_q[i]   <= 1'b0;
      end
    end
  end

  AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dup_vec)); // R5
  AST_ISSUE_QUEUED: assert property (@(posedge clk) disable iff (rst)
    iss_take |-> st_q[iss_idx] == SL_QUEUED); // R7
endmodule

// File: rtl/pf_delayed_access.sv
module pf_delayed_access #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pf_valid,
  input  logic              pf_store,
  input  logic [LINE_W-1:0] pf_line,
  output logic              lk_valid,
  output logic [LINE_W-1:0] lk_line,
  input  logic              lk_hit,
  input  logic              lk_fault,
  output logic              mem_req_valid,
  output logic              mem_req_excl,
  output logic [LINE_W-1:0] mem_req_line,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_line,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_excl,
  input  logic              dem_valid,
  input  logic [LINE_W-1:0] dem_line,
  output logic              dem_join,
  output logic              dem_done,
  output logic              dem_retry,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [LINE_W-1:0] snp_line
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             alloc_ok, fifo_empty, take, drop;
  logic [IDX_W-1:0] alloc_idx, head_idx;
  logic [LINE_W-1:0] iss_line;
  logic             iss_excl, rsp_hit, rsp_excl, rsp_merged, rsp_poison, dem_hit;

  pf_slots #(.N(DEPTH), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_slots (
    .clk(clk), .rst(rst),
    .alloc(pf_valid), .alloc_line(pf_line), .alloc_excl(pf_store),
    .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
    .iss_take(take), .iss_drop(drop), .iss_idx(head_idx),
    .iss_line(iss_line), .iss_excl(iss_excl),
    .rsp_valid(mem_rsp_valid), .rsp_line(mem_rsp_line),
    .rsp_hit(rsp_hit), .rsp_excl(rsp_excl), .rsp_merged(rsp_merged), .rsp_poison(rsp_poison),
    .dem_valid(dem_valid), .dem_line(dem_line), .dem_hit(dem_hit),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_line(snp_line)
  );

  pf_order_fifo #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_order (
    .clk(clk), .rst(rst),
    .push(alloc_ok), .push_idx(alloc_idx),
    .pop(take), .head_idx(head_idx), .empty(fifo_empty)
  );

  assign lk_valid = !fifo_empty && !mem_req_valid;
  assign lk_line  = iss_line;
  assign take     = lk_valid;
  assign drop     = lk_hit || lk_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req_valid <= 1'b0;
      mem_req_excl  <= 1'b0;
      mem_req_line  <= '0;
      fill_valid    <= 1'b0;
      fill_line     <= '0;
      fill_excl     <= 1'b0;
      dem_join      <= 1'b0;
      dem_done      <= 1'b0;
      dem_retry     <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
      if (take && !drop) begin
        mem_req_valid <= 1'b1;
        mem_req_excl  <= iss_excl;
        mem_req_line  <= iss_line;
      end
      fill_valid <= rsp_hit && !rsp_poison;
      fill_line  <= mem_rsp_line;
      fill_excl  <= rsp_excl;
      dem_join   <= dem_hit;
      dem_done   <= rsp_hit && rsp_merged && !rsp_poison;
      dem_retry  <= rsp_hit && rsp_merged && rsp_poison;
    end
  end

  AST_FILL_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> $past(mem_rsp_valid)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line)); // R4
  AST_DONE_OR_RETRY: assert property (@(posedge clk) disable iff (rst)
    !(dem_done && dem_retry)); // R9
  AST_DONE_WITH_FILL: assert property (@(posedge clk) disable iff (rst)
    dem_done |-> fill_valid); // R8
endmodule

// File: tb/tb_pf_delayed_access.sv
`timescale 1ns/1ps
module tb_pf_delayed_access;
  localparam int LW = 26;

  logic clk = 1'b0, rst = 1'b1;
  logic pf_valid = 0, pf_store = 0; logic [LW-1:0] pf_line = '0;
  logic lk_valid, lk_hit, lk_fault; logic [LW-1:0] lk_line;
  logic mem_req_valid, mem_req_excl; logic [LW-1:0] mem_req_line;
  logic mem_req_ready = 1'b1;
  logic mem_rsp_valid = 0; logic [LW-1:0] mem_rsp_line = '0;
  logic fill_valid, fill_excl; logic [LW-1:0] fill_line;
  logic dem_valid = 0; logic [LW-1:0] dem_line = '0;
  logic dem_join, dem_done, dem_retry;
  logic snp_valid = 0, snp_write = 0; logic [LW-1:0] snp_line = '0;

  int n_chk = 0, n_err = 0, n_req = 0;
  bit done = 0;
  logic [LW:0] exp_req [$];
  logic [LW:0] exp_fill [$];
  logic [LW-1:0] present [4];
  logic [LW-1:0] fault_line;

  always #2 clk = ~clk;

  pf_delayed_access dut (.*);

  always_comb begin
    lk_hit = 1'b0;
    for (int i = 0; i < 4; i++) if (lk_valid && lk_line == present[i]) lk_hit = 1'b1;
    lk_fault = lk_valid && (lk_line == fault_line);
  end

  task automatic check(string req, logic [LW:0] got, logic [LW:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mem_req_valid && mem_req_ready) begin
      n_req++;
      if (exp_req.size() == 0) check("R2/R5 unexpected request", {mem_req_excl, mem_req_line}, '1);
      else check("R1/R7 request", {mem_req_excl, mem_req_line}, exp_req.pop_front());
    end
    if (!rst && fill_valid) begin
      if (exp_fill.size() == 0) check("R9/R12 unexpected fill", {fill_excl, fill_line}, '1);
      else check("R4/R10 fill", {fill_excl, fill_line}, exp_fill.pop_front());
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [LW-1:0] line, logic st, bit expect_req);
    @(negedge clk);
    pf_valid = 1; pf_line = line; pf_store = st;
    if (expect_req) exp_req.push_back({st, line});
    @(negedge clk);
    pf_valid = 0;
  endtask

  task automatic respond(logic [LW-1:0] line, bit fill_on, logic excl, logic exp_done, logic exp_retry);
    @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_line = line;
    if (fill_on) exp_fill.push_back({excl, line});
    @(negedge clk);
    mem_rsp_valid = 0;
    check("R8 dem_done", dem_done, exp_done);
    check("R9 dem_retry", dem_retry, exp_retry);
  endtask

  task automatic demand(logic [LW-1:0] line, logic exp_join);
    @(negedge clk);
    dem_valid = 1; dem_line = line;
    @(negedge clk);
    dem_valid = 0;
    check("R8 dem_join", dem_join, exp_join);
  endtask

  task automatic snoop(logic [LW-1:0] line, logic wr);
    @(negedge clk);
    snp_valid = 1; snp_line = line; snp_write = wr;
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int base;
    present[0] = 26'h30; present[1] = 26'h3f0; present[2] = 26'h3f1; present[3] = 26'h3f2;
    fault_line = 26'h31;
    tick(3);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check("R11 reset", {lk_valid, mem_req_valid, fill_valid, dem_join, dem_done, dem_retry}, 0);

    // R1 R4 load then store
    send(26'h10, 0, 1); tick(4);
    respond(26'h10, 1, 0, 0, 0);
    send(26'h20, 1, 1); tick(4);
    respond(26'h20, 1, 1, 0, 0);

    // R2 cache-present, R3 fault
    base = n_req;
    send(26'h30, 1, 0); tick(4);
    check("R2 present dropped", n_req - base, 0);
    send(26'h31, 0, 0); tick(4);
    check("R3 fault dropped", {fill_valid, n_req - base}, 0);

    // R5 duplicate
    base = n_req;
    send(26'h40, 0, 1); send(26'h40, 1, 0); tick(4);
    check("R5 duplicate one request", n_req - base, 1);
    send(26'h40, 0, 0); tick(4);
    check("R5 duplicate while outstanding", n_req - base, 1);
    respond(26'h40, 1, 0, 0, 0);

    // R7 order, R12 out-of-order responses
    send(26'h50, 0, 1); send(26'h51, 1, 1); send(26'h52, 0, 1); tick(8);
    respond(26'h52, 1, 0, 0, 0);
    respond(26'h50, 1, 0, 0, 0);
    respond(26'h51, 1, 1, 0, 0);

    // R6 full table
    base = n_req;
    for (int i = 0; i < 4; i++) send(26'h60 + i, 0, 1);
    send(26'h64, 0, 0); tick(12);
    check("R6 full drops hint", n_req - base, 4);
    for (int i = 0; i < 4; i++) respond(26'h60 + i, 1, 0, 0, 0);
    send(26'h64, 0, 1); tick(4);
    check("R6 accepts after free", n_req - base, 5);
    respond(26'h64, 1, 0, 0, 0);

    // R8 merge
    base = n_req;
    send(26'h70, 0, 1); tick(4);
    demand(26'h70, 1);
    demand(26'h71, 0);
    tick(2);
    check("R8 no duplicate request", n_req - base, 1);
    respond(26'h70, 1, 0, 1, 0);

    // R9 remote write poisons
    send(26'h80, 1, 1); tick(4);
    demand(26'h80, 1);
    snoop(26'h80, 1);
    respond(26'h80, 0, 0, 0, 1);

    // R10 remote read downgrades
    send(26'h90, 1, 1); tick(4);
    snoop(26'h90, 0);
    respond(26'h90, 1, 0, 0, 0);

    // R12 stray response
    respond(26'haa, 0, 0, 0, 0);
    tick(3);
    check("R12 stray no fill", fill_valid, 0);

    check("R4 all requests seen", exp_req.size(), 0);
    check("R4 all fills seen", exp_fill.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule